// File: doc/BRIEF.md
# Watchdog Supervisor with Reset Pulse Generation

This block supervises a processor through a single watchdog line. The processor's firmware must toggle the line at regular intervals. If the line stays quiet for longer than the selected timeout, the block drives an active-low reset output for a fixed number of timebase ticks. It also drops a health flag that stays low until the firmware toggles the line again. Counting advances only on cycles where a timebase tick enable is high, so a single clock domain can serve both a free-running external tick and an internally divided one.

The timeout depends on history. After any reset, the timer uses a long start-up limit. This gives start-up code time to finish before it has to service the watchdog. The first detected toggle arms the normal limit, which depends on two selects: an external/internal tick select and, for the internal tick, a short/long select. A timeout, a supply-fail flag or an external request brings the block back to its post-reset state. A supply fault also forces the health flag high. Reset pulse length is fixed at build time by a variant parameter.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0 and `wd_ok_o` is 1. After `rst_n` rises, `rst_out_n` goes high on the clock edge where the PULSE-th tick is counted. PULSE is `RST_SHORT` (default 512) when `LONG_PULSE`=0 and `RST_LONG` (default 2048) when `LONG_PULSE`=1.
- R2: Both the timeout counter and the reset pulse counter advance only on cycles with `tick_i`=1. The timeout counter holds at zero while `rst_out_n` is 0, so each watch period starts from zero.
- R3: Until the first detected `wdi_i` transition after `rst_out_n` rises, the timeout limit is the start-up limit. That limit is `EXT_POST` (default 4096) when `ext_tick_i`=1 and `INT_LONG` (default 16384) when `ext_tick_i`=0. Transitions seen while `rst_out_n` is 0 do not arm the normal limit.
- R4: Once armed, the timeout limit is `EXT_NORM` (default 1024) when `ext_tick_i`=1. When `ext_tick_i`=0, it is `INT_SHORT` (default 1024) for `fast_sel_i`=1 and `INT_LONG` for `fast_sel_i`=0.
- R5: Every transition of `wdi_i`, rising or falling, passes a two-flop synchronizer and then restarts the counter at zero on the third clock edge after the change. With a tick on every clock, toggles spaced at most L clocks apart never cause a timeout.
- R6: When the counter reaches the active limit L, `rst_out_n` falls on that edge, which is L tick edges after the last restart. It stays low for PULSE ticks. The armed state is then cleared, so the next watch period uses the start-up limit again.
- R7: `wd_ok_o` falls on the timeout edge and stays low through the reset pulse. It rises only on the third clock edge after the next `wdi_i` transition.
- R8: `supply_fail_i`=1 forces `wd_ok_o` to 1 and holds `rst_out_n` at 0 from the next edge. After the flag drops, `rst_out_n` rises on the (PULSE+1)-th clock edge, with a tick on every clock.
- R9: `rst_req_i`=1 holds `rst_out_n` at 0 and times its release like R8, but leaves `wd_ok_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the driver |
| tick_i | input | 1 | Timebase tick enable, one clock wide |
| ext_tick_i | input | 1 | 1: external tick limits; 0: internal timebase limits |
| fast_sel_i | input | 1 | Internal timebase only: 1 selects the short armed limit |
| wdi_i | input | 1 | Watchdog line from firmware, asynchronous |
| supply_fail_i | input | 1 | Supply fault flag, synchronous, active high |
| rst_req_i | input | 1 | External reset request, synchronous, active high |
| rst_out_n | output | 1 | Reset output, active low |
| wd_ok_o | output | 1 | Watchdog health flag, low after a timeout |

## Verification
The bench samples on the falling clock edge and counts each result against the edge on which it is due. A `wdi_i` change reaches the counter and `wd_ok_o` on the third rising edge, so a kick followed by silence shows L+2 high samples before the reset falls. `wd_ok_o` is checked as still low on the second sample and high on the third. A timeout pulse gives exactly PULSE low samples. A release of the supply-fail flag or the request gives PULSE+1 low samples, because the hold state needs one extra edge to start counting. The random kick intervals straddle the armed limit, and the bench predicts a timeout exactly when the spacing exceeds L.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    RP_IDLE  = 2'd0,
    RP_HOLD  = 2'd1,
    RP_COUNT = 2'd2
  } rp_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wd_edge_sync.sv
module wd_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // any change of the synchronized level, rising or falling
  assign edge_o = s2_q ^ prev_q;

endmodule

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int TW        = 15,
  parameter int EXT_NORM  = 1024,
  parameter int EXT_POST  = 4096,
  parameter int INT_SHORT = 1024,
  parameter int INT_LONG  = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic edge_i,
  input  logic ext_tick_i,
  input  logic fast_sel_i,
  output logic expire_o,
  output logic armed_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic [TW-1:0] lim_norm, lim_post, lim;

  always_comb begin
    if (ext_tick_i) begin
      lim_norm = TW'(EXT_NORM);
      lim_post = TW'(EXT_POST);
    end else begin
      lim_norm = fast_sel_i ? TW'(INT_SHORT) : TW'(INT_LONG);
      lim_post = TW'(INT_LONG);
    end
    lim = armed_q ? lim_norm : lim_post;
  end

  // >= keeps a mid-period mode change from running the counter past the limit
  assign expire_o = !hold_i && !edge_i && tick_i && (cnt_q >= (lim - TW'(1)));
  assign armed_o  = armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (hold_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (edge_i) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (tick_i) begin
      cnt_d = expire_o ? '0 : cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assert_idle_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0 && !armed_q));

  assert_edge_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !hold_i) |=> (cnt_q == '0 && armed_q));

endmodule

// File: rtl/wd_rst_pulse.sv
module wd_rst_pulse
  import wdog_pkg::*;
#(
  parameter int LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic fire_i,
  output logic active_o
);

  localparam int PW = $clog2(LEN + 1);

  rp_state_e     state_q, state_d;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (hold_i) begin
      state_d = RP_HOLD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        RP_HOLD: begin
          state_d = RP_COUNT;
          cnt_d   = '0;
        end
        RP_COUNT: begin
          if (tick_i) begin
            if (cnt_q == PW'(LEN - 1)) state_d = RP_IDLE;
            else                       cnt_d   = cnt_q + PW'(1);
          end
        end
        default: begin
          if (fire_i) begin
            state_d = RP_COUNT;
            cnt_d   = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RP_COUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q != RP_IDLE);

  assert_pulse_waits_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RP_COUNT && !tick_i && !hold_i) |=> (state_q == RP_COUNT && $stable(cnt_q)));

  assert_hold_keeps_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (state_q == RP_HOLD));

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
  import wdog_pkg::*;
#(
  parameter int EXT_NORM   = 1024,
  parameter int EXT_POST   = 4096,
  parameter int INT_SHORT  = 1024,
  parameter int INT_LONG   = 16384,
  parameter int RST_SHORT  = 512,
  parameter int RST_LONG   = 2048,
  parameter bit LONG_PULSE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ext_tick_i,
  input  logic fast_sel_i,
  input  logic wdi_i,
  input  logic supply_fail_i,
  input  logic rst_req_i,
  output logic rst_out_n,
  output logic wd_ok_o
);

  localparam int MAX_LIM = max4(EXT_NORM, EXT_POST, INT_SHORT, INT_LONG);
  localparam int TW      = $clog2(MAX_LIM + 1);

  logic wd_edge;
  logic expire;
  logic armed;
  logic rst_active;
  logic ok_q, ok_d;

  wd_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (wdi_i),
    .edge_o (wd_edge)
  );

  wd_timer #(
    .TW        (TW),
    .EXT_NORM  (EXT_NORM),
    .EXT_POST  (EXT_POST),
    .INT_SHORT (INT_SHORT),
    .INT_LONG  (INT_LONG)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .hold_i     (rst_active),
    .edge_i     (wd_edge),
    .ext_tick_i (ext_tick_i),
    .fast_sel_i (fast_sel_i),
    .expire_o   (expire),
    .armed_o    (armed)
  );

  if (LONG_PULSE) begin : g_long_pulse
    wd_rst_pulse #(.LEN(RST_LONG)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .hold_i   (supply_fail_i | rst_req_i),
      .fire_i   (expire),
      .active_o (rst_active)
    );
  end else begin : g_short_pulse
    wd_rst_pulse #(.LEN(RST_SHORT)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .hold_i   (supply_fail_i | rst_req_i),
      .fire_i   (expire),
      .active_o (rst_active)
    );
  end

  // health flag: supply fault wins, then timeout, then a line transition
  always_comb begin
    ok_d = ok_q;
    if (supply_fail_i)  ok_d = 1'b1;
    else if (expire)    ok_d = 1'b0;
    else if (wd_edge)   ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b1;
    else        ok_q <= ok_d;
  end

  assign wd_ok_o   = ok_q;
  assign rst_out_n = !rst_active;

  assert_expire_starts_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !rst_out_n);

  assert_ok_low_on_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !supply_fail_i) |=> !wd_ok_o);

  assert_fault_forces_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail_i |=> (wd_ok_o && !rst_out_n));

  assert_request_holds_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> !rst_out_n);

  assert_arm_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wd_edge));

endmodule

// File: tb/tb_wdog_supervisor.sv
`timescale 1ns/1ps
module tb_wdog_supervisor;

  localparam int EXT_NORM  = 20;
  localparam int EXT_POST  = 60;
  localparam int INT_SHORT = 24;
  localparam int INT_LONG  = 100;
  localparam int RST_SHORT = 8;
  localparam int RST_LONG  = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick_i, ext_tick_i, fast_sel_i, wdi_i, supply_fail_i, rst_req_i;
  logic rst_a, ok_a, rst_b, ok_b;
  int   tick_div;
  int   n_checks;
  int   n_fail;

  wdog_supervisor #(
    .EXT_NORM(EXT_NORM), .EXT_POST(EXT_POST), .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG),
    .RST_SHORT(RST_SHORT), .RST_LONG(RST_LONG), .LONG_PULSE(1'b0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_tick_i(ext_tick_i),
    .fast_sel_i(fast_sel_i), .wdi_i(wdi_i), .supply_fail_i(supply_fail_i),
    .rst_req_i(rst_req_i), .rst_out_n(rst_a), .wd_ok_o(ok_a)
  );

  wdog_supervisor #(
    .EXT_NORM(EXT_NORM), .EXT_POST(EXT_POST), .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG),
    .RST_SHORT(RST_SHORT), .RST_LONG(RST_LONG), .LONG_PULSE(1'b1)
  ) dut_lp (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_tick_i(ext_tick_i),
    .fast_sel_i(fast_sel_i), .wdi_i(wdi_i), .supply_fail_i(supply_fail_i),
    .rst_req_i(rst_req_i), .rst_out_n(rst_b), .wd_ok_o(ok_b)
  );

  // expected values from the requirements
  function automatic int armed_limit(input bit ext, input bit fast);
    if (ext) return EXT_NORM;
    return fast ? INT_SHORT : INT_LONG;
  endfunction

  function automatic int post_limit(input bit ext);
    return ext ? EXT_POST : INT_LONG;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // count samples (current one included) while rst_out_n stays low
  task automatic meas_low(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (rst_a || n > 5000) break;
      n++;
    end
  endtask

  task automatic meas_high(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (!rst_a || n > 5000) break;
      n++;
    end
  endtask

  // toggle the line, then count high samples until the timeout
  task automatic kick_meas(output int nh, output int ok2, output int ok3);
    int j;
    wdi_i = ~wdi_i;
    nh = 0;
    j  = 0;
    forever begin
      @(negedge clk);
      j++;
      if (j == 2) ok2 = ok_a;
      if (j == 3) ok3 = ok_a;
      if (!rst_a || nh > 5000) break;
      nh++;
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin : tick_gen
    int ph;
    ph = 0;
    tick_i = 1'b1;
    forever begin
      @(negedge clk);
      if (tick_div <= 1) tick_i = 1'b1;
      else begin
        ph = (ph + 1) % tick_div;
        tick_i = (ph == 0);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin : main
    int n, ok2, ok3, fa, fb, lows, d, lim;
    n_checks = 0; n_fail = 0; tick_div = 1;
    rst_n = 1'b0; ext_tick_i = 1'b1; fast_sel_i = 1'b0; wdi_i = 1'b0;
    supply_fail_i = 1'b0; rst_req_i = 1'b0;
    void'($urandom(32'd1234));
    ok2 = 0; ok3 = 0;

    // R1 reset state
    repeat (4) @(negedge clk);
    check_eq("R1 rst_out_n in reset", rst_a, 0);
    check_eq("R1 wd_ok_o in reset", ok_a, 1);
    check_eq("R1 long variant ok in reset", ok_b, 1);

    // R1 power-on pulse for both variants
    rst_n = 1'b1;
    fa = -1; fb = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (rst_a && fa < 0) fa = i;
      if (rst_b && fb < 0) fb = i;
    end
    check_eq("R1 short pulse release edge", fa, RST_SHORT);
    check_eq("R1 long pulse release edge", fb, RST_LONG);

    // fresh start
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    meas_low(n);
    check_eq("R1 pulse after reset", n, RST_SHORT);

    // R3 start-up limit, no kick
    meas_high(n);
    check_eq("R3 start-up limit external", n, post_limit(1'b1));
    check_eq("R7 ok low at timeout", ok_a, 0);
    meas_low(n);
    check_eq("R6 pulse after timeout", n, RST_SHORT);
    check_eq("R7 ok stays low through pulse", ok_a, 0);

    // R4 armed external limit, R7 status rises on third edge
    kick_meas(n, ok2, ok3);
    check_eq("R4 armed external limit", n, armed_limit(1'b1, 1'b0) + 2);
    check_eq("R7 ok still low at second edge", ok2, 0);
    check_eq("R7 ok high at third edge", ok3, 1);

    // R3/R6 toggle during pulse ignored, start-up limit restored
    @(negedge clk);
    wdi_i = ~wdi_i;
    meas_low(n);
    check_eq("R6 pulse remainder", n, RST_SHORT - 1);
    meas_high(n);
    check_eq("R6 start-up limit restored", n, post_limit(1'b1));
    meas_low(n);

    // R4 internal timebase, short select
    ext_tick_i = 1'b0; fast_sel_i = 1'b1;
    kick_meas(n, ok2, ok3);
    check_eq("R4 armed internal short", n, armed_limit(1'b0, 1'b1) + 2);
    meas_low(n);
    meas_high(n);
    check_eq("R3 start-up limit internal", n, post_limit(1'b0));
    meas_low(n);
    fast_sel_i = 1'b0;
    kick_meas(n, ok2, ok3);
    check_eq("R4 armed internal long", n, armed_limit(1'b0, 1'b0) + 2);
    meas_low(n);

    // R5 regular kicks of both polarities keep it alive
    ext_tick_i = 1'b1;
    lows = 0;
    for (int k = 0; k < 30; k++) begin
      wdi_i = ~wdi_i;
      repeat (15) begin
        @(negedge clk);
        if (!rst_a) lows++;
      end
    end
    check_eq("R5 no timeout with regular kicks", lows, 0);
    check_eq("R7 ok high after kicks", ok_a, 1);

    // R5/R6 random spacing around the armed limit
    lim = armed_limit(1'b1, 1'b0);
    for (int it = 0; it < 40; it++) begin
      d = lim - 3 + $urandom_range(6);
      wdi_i = ~wdi_i;
      if (d <= lim) begin
        lows = 0;
        repeat (d) begin
          @(negedge clk);
          if (!rst_a) lows++;
        end
        check_eq("R5 random spacing within limit", lows, 0);
      end else begin
        fa = -1;
        for (int j = 1; j <= lim + 3; j++) begin
          @(negedge clk);
          if (!rst_a && fa < 0) fa = j;
        end
        check_eq("R6 random spacing timeout sample", fa, lim + 3);
        meas_low(n);
        check_eq("R6 random timeout pulse", n, RST_SHORT);
      end
    end

    // R8 supply fault
    meas_high(n);
    check_eq("R7 ok low before fault", ok_a, 0);
    @(negedge clk);
    supply_fail_i = 1'b1;
    @(negedge clk);
    check_eq("R8 fault forces ok high", ok_a, 1);
    lows = 0;
    repeat (20) begin
      @(negedge clk);
      if (!rst_a) lows++;
    end
    check_eq("R8 reset held during fault", lows, 20);
    supply_fail_i = 1'b0;
    meas_low(n);
    check_eq("R8 release timing", n, RST_SHORT + 1);
    meas_high(n);
    check_eq("R8 start-up limit after fault", n, post_limit(1'b1));
    meas_low(n);

    // R9 external request leaves the status alone
    rst_req_i = 1'b1;
    @(negedge clk);
    check_eq("R9 request asserts reset", rst_a, 0);
    repeat (10) @(negedge clk);
    check_eq("R9 ok unchanged by request", ok_a, 0);
    rst_req_i = 1'b0;
    meas_low(n);
    check_eq("R9 release timing", n, RST_SHORT + 1);

    // R2 counting gated by tick
    tick_div = 3;
    meas_high(n);
    check_range("R2 timeout with tick every third clock", n,
                3 * post_limit(1'b1) - 3, 3 * post_limit(1'b1) + 3);
    meas_low(n);
    check_range("R2 pulse with tick every third clock", n,
                3 * RST_SHORT - 3, 3 * RST_SHORT + 3);
    tick_div = 1;

    finish_run();
  end

endmodule